// File: doc/BRIEF.md
# Frequency-Loop Lock Detector

This block decides whether a frequency-locked loop has settled. It samples the loop controller's increment and decrement correction pulses on the rising edge of a sampled monitor clock and drives one lock flag. An acquisition attempt starts when the successive-approximation search reports end of conversion while the two-bit unlock-programming field holds 2'b00. After that start, the block opens a short window. If the increment input rises twice, or the decrement input rises twice, inside that window, the loop is declared locked.

Once locked, the block watches the levels of the same two inputs rather than their edges. A sustained run of one correction direction means the loop has drifted, so lock is dropped and the detector goes back to waiting for the next end of conversion. An enable input holds the whole detector idle and forces the flag low.

The controller is a four-state machine:
- `ST_OFF`: disabled.
- `ST_WAIT`: enabled, waiting for a start.
- `ST_ACQ`: the acquire window is open.
- `ST_LOCK`: locked.

Its transitions are:
- `OFF->WAIT`: enable is high.
- `WAIT->ACQ`: the start condition is seen.
- `ACQ->LOCK`: a second same-kind rising edge is seen.
- `ACQ->WAIT`: the window expires.
- `LOCK->WAIT`: a high run completes.
- `any->OFF`: enable is low.

Top module: `fll_lock_fsm`

## Requirements
- R1: After reset, lock_o is low. The detector needs one clock edge with enable high before it reacts to a start condition.
- R2: An acquire attempt starts at a clock edge, in the waiting state, that samples eoc_i=1 and unlock_prog_i=2'b00. Both rising-edge counts are cleared at that edge.
- R3: When unlock_prog_i is not 2'b00, eoc_i does not start an attempt and lock_o stays low.
- R4: A rising edge is an input sampled high at a clock edge after being sampled low at the previous edge. Lock_o goes high right after the edge that samples the second rising edge of inc_i, or the second rising edge of dec_i. That edge must be one of the six edges following the start edge. The two edges need not be adjacent.
- R5: One rising edge of inc_i plus one of dec_i does not set lock. Edges of the two inputs are counted separately.
- R6: If the six window edges pass without two same-kind rising edges, the detector returns to waiting. An edge on the seventh cycle does not set lock. An edge on the sixth cycle does set lock.
- R7: While locked, lock_o falls right after the fourth consecutive edge that samples inc_i high, or the fourth that samples dec_i high. The detector then waits for a new start.
- R8: While locked, any edge that samples an input low restarts that input's high run. A run of three does not clear lock. Alternating inc_i/dec_i highs do not combine into a run.
- R9: While enable_i is low, lock_o is low at once and the detector is held off. After enable_i returns high, one edge passes before a start condition is accepted.
- R10: During an open window or while locked, eoc_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampled monitor clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Detector enable; low holds it off and forces lock low |
| eoc_i | input | 1 | End-of-conversion flag from the approximation search |
| unlock_prog_i | input | 2 | Unlock programming field; only 2'b00 starts an attempt |
| inc_i | input | 1 | Increment correction from the loop controller |
| dec_i | input | 1 | Decrement correction from the loop controller |
| lock_o | output | 1 | Lock flag |

## Verification
Two functions can land on the same clock edge, and the bench provokes both:
- The second same-kind rising edge can arrive on the sixth and last window edge. Window expiry and lock acquisition then coincide. The bench places a decrement edge exactly there and expects lock, and places an edge one cycle later and expects no lock.
- A qualifying unlock run or lock acquisition can meet a falling enable. The bench drops enable while locked and expects the flag low before the next edge.

A behavioural reference model judges every cycle in between.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACQ  = 2'd2,
        ST_LOCK = 2'd3
    } ld_state_e;

    localparam int CH_INC = 0;
    localparam int CH_DEC = 1;
    localparam int NCH    = 2;
endpackage

// File: rtl/ld_channel.sv
module ld_channel #(
    parameter int EDGE_CNT = 2,
    parameter int RUN_LEN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sig,
    input  logic acq_clr,
    input  logic acq_act,
    input  logic run_act,
    output logic edge_hit,
    output logic run_hit
);
    localparam int EW = $clog2(EDGE_CNT + 1);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic          sig_q;
    logic          rise;
    logic [EW-1:0] edge_cnt;
    logic [RW-1:0] run_cnt;

    // previous sample of the input for rising-edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;

    // rising edges seen inside the acquire window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  edge_cnt <= '0;
        else if (!enable || acq_clr) edge_cnt <= '0;
        else if (acq_act && rise)    edge_cnt <= edge_cnt + 1'b1;
    end

    assign edge_hit = acq_act && rise && (edge_cnt == EW'(EDGE_CNT - 1));

    // consecutive high samples while locked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          run_cnt <= '0;
        else if (!enable || !run_act || !sig) run_cnt <= '0;
        else if (run_cnt != RW'(RUN_LEN - 1)) run_cnt <= run_cnt + 1'b1;
    end

    assign run_hit = run_act && sig && (run_cnt == RW'(RUN_LEN - 1));
endmodule

// File: rtl/ld_window.sv
module ld_window #(
    parameter int WIN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clr,
    input  logic act,
    output logic last
);
    localparam int WW = $clog2(WIN_LEN + 1);

    logic [WW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!enable || clr) cnt <= '0;
        else if (act)            cnt <= cnt + 1'b1;
    end

    assign last = act && (cnt == WW'(WIN_LEN - 1));
endmodule

// File: rtl/fll_lock_fsm.sv
module fll_lock_fsm
    import lockdet_pkg::*;
#(
    parameter int               WIN_LEN  = 6,
    parameter int               EDGE_CNT = 2,
    parameter int               RUN_LEN  = 4,
    parameter int               PROG_W   = 2,
    parameter logic [PROG_W-1:0] PROG_SEL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              eoc_i,
    input  logic [PROG_W-1:0] unlock_prog_i,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic              lock_o
);
    ld_state_e      state, nxt;
    logic [NCH-1:0] ch_sig;
    logic [NCH-1:0] edge_hit;
    logic [NCH-1:0] run_hit;
    logic           start_hit;
    logic           acq_act;
    logic           run_act;
    logic           win_last;

    assign ch_sig[CH_INC] = inc_i;
    assign ch_sig[CH_DEC] = dec_i;

    assign start_hit = enable_i && (state == ST_WAIT) && eoc_i
                       && (unlock_prog_i == PROG_SEL);
    assign acq_act   = enable_i && (state == ST_ACQ);
    assign run_act   = enable_i && (state == ST_LOCK);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ld_channel #(
            .EDGE_CNT(EDGE_CNT),
            .RUN_LEN (RUN_LEN)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable_i),
            .sig     (ch_sig[g]),
            .acq_clr (start_hit),
            .acq_act (acq_act),
            .run_act (run_act),
            .edge_hit(edge_hit[g]),
            .run_hit (run_hit[g])
        );
    end

    ld_window #(
        .WIN_LEN(WIN_LEN)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable_i),
        .clr   (start_hit),
        .act   (acq_act),
        .last  (win_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!enable_i) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_WAIT;
                ST_WAIT: if (start_hit) nxt = ST_ACQ;
                ST_ACQ: begin
                    if (|edge_hit)     nxt = ST_LOCK;
                    else if (win_last) nxt = ST_WAIT;
                end
                ST_LOCK: if (|run_hit) nxt = ST_WAIT;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        lock_o = (state == ST_LOCK) && enable_i;
    end
endmodule

// File: rtl/fll_lock_chk.sv
module fll_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic inc_i,
    input logic dec_i,
    input logic lock_o
);
    // R9
    off_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !lock_o);

    // R4
    lock_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> (($past(inc_i) && !$past(inc_i, 2))
                        || ($past(dec_i) && !$past(dec_i, 2))));

    // R7
    unlock_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_o) && enable_i && $past(enable_i)) |-> ($past(inc_i) || $past(dec_i)));

    // R8
    quiet_holds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !inc_i && !dec_i) |=> (lock_o || !enable_i));
endmodule

bind fll_lock_fsm fll_lock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable_i(enable_i),
    .inc_i   (inc_i),
    .dec_i   (dec_i),
    .lock_o  (lock_o)
);

// File: tb/test_fll_lock_fsm.sv
module test_fll_lock_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       eoc_i = 1'b0;
    logic [1:0] unlock_prog_i = 2'b00;
    logic       inc_i = 1'b0;
    logic       dec_i = 1'b0;
    logic       lock_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    int m_mode = 0;
    int m_win, m_ie, m_de, m_ir, m_dr;
    bit m_pi, m_pd;

    always #10 clk = ~clk;

    fll_lock_fsm i_fll_lock_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .eoc_i        (eoc_i),
        .unlock_prog_i(unlock_prog_i),
        .inc_i        (inc_i),
        .dec_i        (dec_i),
        .lock_o       (lock_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_win = 0; m_ie = 0; m_de = 0; m_ir = 0; m_dr = 0;
            m_pi = 0; m_pd = 0;
        end else begin
            bit ri, rd;
            ri = inc_i && !m_pi;
            rd = dec_i && !m_pd;
            if (!enable_i) begin
                m_mode = 0;
            end else begin
                case (m_mode)
                    0: m_mode = 1;
                    1: if (eoc_i && unlock_prog_i == 2'b00) begin
                           m_mode = 2; m_win = 0; m_ie = 0; m_de = 0;
                       end
                    2: begin
                           m_win++;
                           if (ri) m_ie++;
                           if (rd) m_de++;
                           if (m_ie >= 2 || m_de >= 2) begin
                               m_mode = 3; m_ir = 0; m_dr = 0;
                           end else if (m_win >= 6) m_mode = 1;
                       end
                    default: begin
                           m_ir = inc_i ? m_ir + 1 : 0;
                           m_dr = dec_i ? m_dr + 1 : 0;
                           if (m_ir >= 4 || m_dr >= 4) m_mode = 1;
                       end
                endcase
            end
            m_pi = inc_i;
            m_pd = dec_i;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lock_o actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic i, input logic d, input logic e);
        inc_i = i; dec_i = d; eoc_i = e;
        @(posedge clk);
        @(negedge clk);
        check(cur_req, lock_o, (m_mode == 3) && enable_i);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0);
    endtask

    task automatic acquire_inc;
        cyc(0, 0, 1); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", lock_o, 1'b0);
        rst_n = 1'b1;
        enable_i = 1'b1;
        cur_req = "R1";
        cyc(0, 0, 1);             // start ignored: still leaving off state
        check("R1", lock_o, 1'b0);
        idle(7);
        check("R1", lock_o, 1'b0);

        // R2 / R4: separated inc edges in the window
        cur_req = "R4";
        cyc(0, 0, 1); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0);
        check("R4", lock_o, 1'b1);
        cyc(0, 0, 0);

        // R10: eoc while locked
        cur_req = "R10";
        cyc(0, 0, 1); cyc(0, 0, 1);
        check("R10", lock_o, 1'b1);

        // R8: short and alternating runs
        cur_req = "R8";
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
        check("R8", lock_o, 1'b1);
        cyc(1, 0, 0); cyc(0, 1, 0); cyc(1, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);
        check("R8", lock_o, 1'b1);

        // R7: four-high inc run
        cur_req = "R7";
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
        check("R7", lock_o, 1'b1);
        cyc(1, 0, 0);
        check("R7", lock_o, 1'b0);
        cyc(0, 0, 0);

        // R5: one of each kind
        cur_req = "R5";
        cyc(0, 0, 1); cyc(1, 0, 0); cyc(0, 1, 0); idle(5);
        check("R5", lock_o, 1'b0);

        // R6: second edge on seventh cycle
        cur_req = "R6";
        cyc(0, 0, 1); cyc(1, 0, 0); idle(5); cyc(1, 0, 0);
        check("R6", lock_o, 1'b0);
        cyc(0, 0, 0);
        // R6: second edge on sixth cycle (window end and lock together)
        cyc(0, 0, 1); cyc(0, 1, 0); idle(4); cyc(0, 1, 0);
        check("R6", lock_o, 1'b1);

        // R7: four-high dec run
        cur_req = "R7";
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        check("R7", lock_o, 1'b1);
        cyc(0, 1, 0);
        check("R7", lock_o, 1'b0);
        cyc(0, 0, 0);

        // R3: other programming values
        cur_req = "R3";
        unlock_prog_i = 2'b01;
        cyc(0, 0, 1); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
        check("R3", lock_o, 1'b0);
        unlock_prog_i = 2'b11;
        cyc(0, 0, 1); cyc(0, 1, 0); cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);
        check("R3", lock_o, 1'b0);
        unlock_prog_i = 2'b00;

        // R9: enable drop while locked
        cur_req = "R9";
        acquire_inc();
        check("R9", lock_o, 1'b1);
        enable_i = 1'b0;
        #1;
        check("R9", lock_o, 1'b0);
        cyc(0, 0, 0); cyc(0, 0, 0);
        enable_i = 1'b1;
        cyc(0, 0, 1); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
        check("R9", lock_o, 1'b0);
        cur_req = "R2";
        acquire_inc();
        check("R2", lock_o, 1'b1);
        idle(3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule